// File: doc/BRIEF.md
# Sleep-Mode and Reset Sequencer for an 8-bit Controller

This block decides when the CPU clock, the peripheral clock and the oscillator of a small 8-bit controller run. Software asks for a light sleep (idle) or a deep sleep (power-down). In idle the CPU stops and the timers, serial port and interrupt logic keep their clock. Any enabled interrupt or the reset pin ends idle. In power-down the oscillator stops, and only a qualified hardware reset brings the controller back.

The block counts machine cycles of `MC_CLKS` oscillator clocks. The external reset pin must be held high for two whole machine cycles of running oscillator before the block emits an internal reset pulse. That pulse lasts exactly one machine cycle. A brown-out flag holds the CPU and peripherals off while the oscillator runs. Once the supply recovers, the block waits `BOD_MCYC` machine cycles and then emits the same reset pulse. For every reset the block reports whether RAM can be trusted. It can after a pin reset, and it cannot after a brown-out.

Top module: `pmr_power_manager`

## Requirements
- R1: When `rst_pin` has been high for 2*MC_CLKS consecutive clocks with `osc_en` high, `sys_rst` rises after the next clock edge and `keep_ram` reads 1. A shorter high period produces no reset.
- R2: Each `sys_rst` pulse stays high for exactly MC_CLKS clocks, and `cpu_en` is 0 while it is high.
- R3: An `idle_req` accepted while `cpu_en` is 1 drops `cpu_en` on the next clock. `periph_en` and `osc_en` stay at 1.
- R4: In idle, a high `irq_pending` returns `cpu_en` to 1 on the next clock.
- R5: In idle, a high `rst_pin` returns `cpu_en` to 1 on the next clock. The CPU then runs until the qualified reset pulse starts.
- R6: A `pdown_req` accepted while `cpu_en` is 1 drives `cpu_en`, `periph_en` and `osc_en` to 0 from the next clock, provided `rst_pin` and `bod_low` are low.
- R7: In power-down, `irq_pending` has no effect, and all three enables stay at 0.
- R8: In power-down, `osc_en` follows a high `rst_pin` at once. `cpu_en` stays at 0 until the qualified reset pulse has ended, and then returns to 1.
- R9: When `idle_req` and `pdown_req` are both high in the same accepted cycle, power-down is entered and `osc_en` goes to 0.
- R10: While `bod_low` is high, and through the recovery delay, `cpu_en` and `periph_en` are 0 and `osc_en` is 1. This holds even from power-down. BOD_MCYC machine cycles after `bod_low` falls, a reset pulse is emitted with `keep_ram` at 0.
- R11: After `por_n` is released, `cpu_en`, `periph_en` and `osc_en` are 1, and `sys_rst` and `keep_ram` are 0.
- R12: Sleep requests made while `cpu_en` is 0 are ignored. For example, requests made during a reset pulse leave the block running once the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| idle_req | input | 1 | Software request for idle, one clock |
| pdown_req | input | 1 | Software request for power-down, one clock |
| irq_pending | input | 1 | An enabled interrupt is pending |
| rst_pin | input | 1 | External reset pin, active high |
| bod_low | input | 1 | Supply below the brown-out threshold |
| cpu_en | output | 1 | CPU clock enable |
| periph_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| sys_rst | output | 1 | Internal reset pulse |
| keep_ram | output | 1 | Last reset keeps RAM valid |

## Verification
A wrong sleep state shows at the enables on the clock after the request or wake event. The enables are decoded directly from that state, so the error cannot hide. A machine-cycle phase or hold counter that is off by one moves the rising edge of `sys_rst` by one or more clocks. For the brown-out delay the shift is a whole machine cycle. A reset counter that is wrong changes the pulse width, and the pulse is measured on every fall. The bench compares every output against a behavioural model on each clock, so any of these faults appears on the first cycle where the outputs differ.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pm_state_t;
endpackage

// File: rtl/pmr_cycle_timer.sv
module pmr_cycle_timer #(
  parameter int MC_CLKS = 12
) (
  input  logic clk,
  input  logic por_n,
  input  logic run,
  output logic mc_tick
);
  localparam int PH_W = $clog2(MC_CLKS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(MC_CLKS - 1);

  logic [PH_W-1:0] phase_q;

  function automatic logic [PH_W-1:0] phase_step(input logic [PH_W-1:0] p);
    return (p == PH_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)   phase_q <= '0;
    else if (run) phase_q <= phase_step(phase_q);
  end

  assign mc_tick = run && (phase_q == PH_LAST);
endmodule

// File: rtl/pmr_reset_qual.sv
module pmr_reset_qual #(
  parameter int MC_CLKS  = 12,
  parameter int BOD_MCYC = 15000
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin,
  input  logic osc_run,
  input  logic mc_tick,
  input  logic bod_low,
  output logic pin_qual,
  output logic bod_qual,
  output logic bod_armed
);
  localparam int QUAL = 2 * MC_CLKS;
  localparam int HW   = $clog2(QUAL + 1);
  localparam int BW   = $clog2(BOD_MCYC);

  logic [HW-1:0] hold_q;
  logic [BW-1:0] bcnt_q;
  logic          armed_q;

  function automatic logic [HW-1:0] hold_step(input logic [HW-1:0] h);
    return (h == HW'(QUAL)) ? h : h + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       hold_q <= '0;
    else if (!rst_pin) hold_q <= '0;
    else if (osc_run) hold_q <= hold_step(hold_q);
  end

  assign pin_qual = rst_pin && osc_run && (hold_q == HW'(QUAL - 1));
  assign bod_qual = armed_q && !bod_low && mc_tick && (bcnt_q == BW'(BOD_MCYC - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      armed_q <= 1'b0;
      bcnt_q  <= '0;
    end else if (bod_low) begin
      armed_q <= 1'b1;
      bcnt_q  <= '0;
    end else if (bod_qual) begin
      armed_q <= 1'b0;
      bcnt_q  <= '0;
    end else if (armed_q && mc_tick) begin
      bcnt_q  <= bcnt_q + 1'b1;
    end
  end

  assign bod_armed = armed_q;
endmodule

// File: rtl/pmr_mode_fsm.sv
module pmr_mode_fsm
  import pmr_pkg::*;
(
  input  logic      clk,
  input  logic      por_n,
  input  logic      cpu_ok,
  input  logic      idle_req,
  input  logic      pdown_req,
  input  logic      irq_pending,
  input  logic      rst_pin,
  input  logic      fire,
  output pm_state_t state
);
  pm_state_t nxt;

  always_comb begin
    nxt = state;
    if (fire) nxt = PM_RUN;
    else begin
      case (state)
        PM_RUN: begin
          if (cpu_ok && pdown_req)     nxt = PM_DOWN;
          else if (cpu_ok && idle_req) nxt = PM_IDLE;
        end
        PM_IDLE: if (irq_pending || rst_pin) nxt = PM_RUN;
        PM_DOWN: nxt = PM_DOWN;
        default: nxt = PM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) state <= PM_RUN;
    else        state <= nxt;
  end
endmodule

// File: rtl/pmr_power_manager.sv
module pmr_power_manager
  import pmr_pkg::*;
#(
  parameter int MC_CLKS  = 12,
  parameter int BOD_MCYC = 15000
) (
  input  logic clk,
  input  logic por_n,
  input  logic idle_req,
  input  logic pdown_req,
  input  logic irq_pending,
  input  logic rst_pin,
  input  logic bod_low,
  output logic cpu_en,
  output logic periph_en,
  output logic osc_en,
  output logic sys_rst,
  output logic keep_ram
);
  localparam int RW = $clog2(MC_CLKS + 1);

  pm_state_t     state;
  logic          mc_tick, pin_qual, bod_qual, bod_armed;
  logic          pin_fire, bod_fire, any_fire;
  logic [RW-1:0] rcnt_q;

  assign osc_en    = (state != PM_DOWN) || rst_pin || bod_armed;
  assign sys_rst   = (rcnt_q != '0);
  assign cpu_en    = (state == PM_RUN) && !sys_rst && !bod_armed;
  assign periph_en = (state != PM_DOWN) && !bod_armed;

  assign pin_fire = pin_qual && !sys_rst;
  assign bod_fire = bod_qual && !sys_rst;
  assign any_fire = pin_fire || bod_fire;

  pmr_cycle_timer #(.MC_CLKS(MC_CLKS)) u_timer (
    .clk(clk), .por_n(por_n), .run(osc_en), .mc_tick(mc_tick)
  );

  pmr_reset_qual #(.MC_CLKS(MC_CLKS), .BOD_MCYC(BOD_MCYC)) u_qual (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .osc_run(osc_en),
    .mc_tick(mc_tick), .bod_low(bod_low), .pin_qual(pin_qual),
    .bod_qual(bod_qual), .bod_armed(bod_armed)
  );

  pmr_mode_fsm u_fsm (
    .clk(clk), .por_n(por_n), .cpu_ok(cpu_en), .idle_req(idle_req),
    .pdown_req(pdown_req), .irq_pending(irq_pending), .rst_pin(rst_pin),
    .fire(any_fire), .state(state)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rcnt_q   <= '0;
      keep_ram <= 1'b0;
    end else if (any_fire) begin
      rcnt_q   <= RW'(MC_CLKS);
      keep_ram <= !bod_fire;
    end else if (sys_rst) begin
      rcnt_q   <= rcnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/pmr_power_manager_chk.sv
module pmr_power_manager_chk #(
  parameter int MC_CLKS = 12
) (
  input logic clk,
  input logic por_n,
  input logic idle_req,
  input logic pdown_req,
  input logic irq_pending,
  input logic rst_pin,
  input logic bod_low,
  input logic cpu_en,
  input logic periph_en,
  input logic osc_en,
  input logic sys_rst,
  input logic keep_ram,
  input logic pin_fire,
  input logic bod_fire
);
  localparam int LW = $clog2(MC_CLKS + 2);
  logic [LW-1:0] len_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       len_q <= '0;
    else if (!sys_rst) len_q <= '0;
    else if (len_q != LW'(MC_CLKS + 1)) len_q <= len_q + 1'b1;
  end

  AST_PIN_RST_KEEPS_RAM: assert property (@(posedge clk) disable iff (!por_n)
    (pin_fire && !bod_fire) |=> (sys_rst && keep_ram)); // R1
  AST_RST_WIDTH: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> (len_q == LW'(MC_CLKS))); // R2
  AST_RST_HOLDS_CPU: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |-> !cpu_en); // R2
  AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_en && idle_req && !pdown_req && !bod_low && !pin_fire && !bod_fire)
      |=> (!cpu_en && periph_en && osc_en)); // R3
  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!por_n)
    (!cpu_en && periph_en && !sys_rst && (irq_pending || rst_pin) && !bod_low
      && !pin_fire && !bod_fire) |=> cpu_en); // R4
  AST_OSC_OFF_ALL_OFF: assert property (@(posedge clk) disable iff (!por_n)
    !osc_en |-> (!cpu_en && !periph_en)); // R6
  AST_PDOWN_IGNORES_IRQ: assert property (@(posedge clk) disable iff (!por_n)
    (!osc_en && irq_pending && !rst_pin && !bod_low) |=> !cpu_en); // R7
  AST_PDOWN_WINS: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_en && pdown_req && idle_req && !bod_low && !pin_fire && !bod_fire)
      |=> (!cpu_en && !periph_en)); // R9
  AST_BOD_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    bod_low |=> (osc_en && !cpu_en && !periph_en)); // R10
  AST_BOD_RST_DROPS_RAM: assert property (@(posedge clk) disable iff (!por_n)
    bod_fire |=> (sys_rst && !keep_ram)); // R10
  AST_RST_KEEPS_OSC: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |-> osc_en); // R12
endmodule

bind pmr_power_manager pmr_power_manager_chk #(.MC_CLKS(MC_CLKS)) u_chk (
  .clk(clk), .por_n(por_n), .idle_req(idle_req), .pdown_req(pdown_req),
  .irq_pending(irq_pending), .rst_pin(rst_pin), .bod_low(bod_low),
  .cpu_en(cpu_en), .periph_en(periph_en), .osc_en(osc_en),
  .sys_rst(sys_rst), .keep_ram(keep_ram), .pin_fire(pin_fire),
  .bod_fire(bod_fire)
);

// File: tb/pmr_power_manager_bench.sv
module pmr_power_manager_bench;
  localparam int MC  = 12;
  localparam int BOD = 4;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic idle_req = 1'b0, pdown_req = 1'b0, irq_pending = 1'b0;
  logic rst_pin = 1'b0, bod_low = 1'b0;
  logic cpu_en, periph_en, osc_en, sys_rst, keep_ram;

  int tests = 0, fails = 0, cycles = 0, rst_len = 0;
  bit seen_rst = 0;
  string cur_req = "R11";

  // behavioural reference state: 0 run, 1 idle, 2 power-down
  int ms = 0, mph = 0, mhold = 0, mbcnt = 0, mrcnt = 0;
  bit marmed = 0, mkeep = 0;

  always #2 clk = ~clk;

  pmr_power_manager #(.MC_CLKS(MC), .BOD_MCYC(BOD)) u_pmr_power_manager (
    .clk(clk), .por_n(por_n), .idle_req(idle_req), .pdown_req(pdown_req),
    .irq_pending(irq_pending), .rst_pin(rst_pin), .bod_low(bod_low),
    .cpu_en(cpu_en), .periph_en(periph_en), .osc_en(osc_en),
    .sys_rst(sys_rst), .keep_ram(keep_ram)
  );

  function automatic bit m_cpu();
    return ms == 0 && mrcnt == 0 && !marmed;
  endfunction
  function automatic bit m_per();
    return ms != 2 && !marmed;
  endfunction
  function automatic bit m_osc();
    return ms != 2 || rst_pin || marmed;
  endfunction

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ms = 0; mph = 0; mhold = 0; mbcnt = 0; mrcnt = 0; marmed = 0; mkeep = 0;
    end else begin
      bit osc, tick, pq, bq, pf, bf, fire, cpu;
      osc  = m_osc();
      cpu  = m_cpu();
      tick = osc && mph == MC - 1;
      pq   = rst_pin && osc && mhold == 2 * MC - 1;
      bq   = marmed && !bod_low && tick && mbcnt == BOD - 1;
      pf   = pq && mrcnt == 0;
      bf   = bq && mrcnt == 0;
      fire = pf || bf;
      if (fire) ms = 0;
      else if (ms == 0 && cpu && pdown_req) ms = 2;
      else if (ms == 0 && cpu && idle_req) ms = 1;
      else if (ms == 1 && (irq_pending || rst_pin)) ms = 0;
      if (osc) mph = (mph + 1) % MC;
      if (!rst_pin) mhold = 0;
      else if (osc && mhold < 2 * MC) mhold++;
      if (bod_low) begin marmed = 1; mbcnt = 0; end
      else if (bq) begin marmed = 0; mbcnt = 0; end
      else if (marmed && tick) mbcnt++;
      if (fire) begin mrcnt = MC; mkeep = !bf; end
      else if (mrcnt > 0) mrcnt--;
    end
  end

  always @(negedge clk) begin
    logic [4:0] act, exp;
    cycles++;
    act = {cpu_en, periph_en, osc_en, sys_rst, keep_ram};
    exp = {m_cpu(), m_per(), m_osc(), mrcnt != 0, mkeep};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s model compare cyc %0d act=%b exp=%b", cur_req, cycles, act, exp);
    end
    if (sys_rst === 1'b1) begin rst_len++; seen_rst = 1; end
    else if (rst_len > 0) begin
      tests++;
      if (rst_len != MC) begin
        fails++;
        $display("FAIL R2 pulse width act=%0d exp=%0d", rst_len, MC);
      end
      rst_len = 0;
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL %s watchdog act=hung exp=done", cur_req);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%b exp=%b", req, what, act, exp);
    end
  endtask

  initial begin
    cyc(3);
    por_n = 1'b1;
    cyc(2);
    cur_req = "R11";
    chk("R11", "cpu_en", cpu_en, 1'b1);
    chk("R11", "periph_en", periph_en, 1'b1);
    chk("R11", "osc_en", osc_en, 1'b1);
    chk("R11", "sys_rst", sys_rst, 1'b0);
    chk("R11", "keep_ram", keep_ram, 1'b0);

    cur_req = "R3";
    idle_req = 1; cyc(1); idle_req = 0; cyc(1);
    chk("R3", "cpu_en", cpu_en, 1'b0);
    chk("R3", "periph_en", periph_en, 1'b1);
    chk("R3", "osc_en", osc_en, 1'b1);

    cur_req = "R4";
    irq_pending = 1; cyc(1); irq_pending = 0; cyc(1);
    chk("R4", "cpu_en", cpu_en, 1'b1);

    cur_req = "R1";
    seen_rst = 0;
    rst_pin = 1; cyc(10); rst_pin = 0; cyc(30);
    chk("R1", "short pin no reset", seen_rst, 1'b0);
    rst_pin = 1; cyc(23);
    chk("R1", "sys_rst before 24", sys_rst, 1'b0);
    cyc(1);
    chk("R1", "sys_rst at 24", sys_rst, 1'b1);
    chk("R1", "keep_ram", keep_ram, 1'b1);
    rst_pin = 0; cyc(15);
    chk("R2", "cpu after pulse", cpu_en, 1'b1);

    cur_req = "R12";
    rst_pin = 1; cyc(24);
    chk("R12", "in pulse", sys_rst, 1'b1);
    rst_pin = 0; pdown_req = 1; cyc(1); pdown_req = 0; idle_req = 1; cyc(1); idle_req = 0;
    cyc(15);
    chk("R12", "osc_en", osc_en, 1'b1);
    chk("R12", "cpu_en", cpu_en, 1'b1);

    cur_req = "R5";
    idle_req = 1; cyc(1); idle_req = 0;
    chk("R5", "idle entered", cpu_en, 1'b0);
    seen_rst = 0;
    rst_pin = 1; cyc(1);
    chk("R5", "cpu wakes", cpu_en, 1'b1);
    chk("R5", "no reset yet", sys_rst, 1'b0);
    cyc(30); rst_pin = 0;
    chk("R5", "reset followed", seen_rst, 1'b1);
    cyc(15);
    chk("R5", "cpu after", cpu_en, 1'b1);

    cur_req = "R6";
    pdown_req = 1; cyc(1); pdown_req = 0;
    chk("R6", "osc_en", osc_en, 1'b0);
    chk("R6", "cpu_en", cpu_en, 1'b0);
    chk("R6", "periph_en", periph_en, 1'b0);
    cur_req = "R7";
    irq_pending = 1; cyc(3); irq_pending = 0; cyc(1);
    chk("R7", "cpu_en", cpu_en, 1'b0);
    chk("R7", "osc_en", osc_en, 1'b0);

    cur_req = "R8";
    rst_pin = 1; #1;
    chk("R8", "osc follows pin", osc_en, 1'b1);
    chk("R8", "cpu held", cpu_en, 1'b0);
    cyc(24);
    chk("R8", "sys_rst", sys_rst, 1'b1);
    chk("R8", "keep_ram", keep_ram, 1'b1);
    rst_pin = 0; cyc(15);
    chk("R8", "cpu back", cpu_en, 1'b1);
    chk("R8", "osc on", osc_en, 1'b1);

    cur_req = "R9";
    idle_req = 1; pdown_req = 1; cyc(1); idle_req = 0; pdown_req = 0; cyc(1);
    chk("R9", "osc_en", osc_en, 1'b0);
    rst_pin = 1; cyc(24); rst_pin = 0; cyc(15);
    chk("R9", "cpu back", cpu_en, 1'b1);

    cur_req = "R10";
    bod_low = 1; cyc(2);
    chk("R10", "cpu_en", cpu_en, 1'b0);
    chk("R10", "periph_en", periph_en, 1'b0);
    chk("R10", "osc_en", osc_en, 1'b1);
    cyc(3); bod_low = 0; seen_rst = 0; cyc(20);
    chk("R10", "cpu in delay", cpu_en, 1'b0);
    chk("R10", "no early reset", seen_rst, 1'b0);
    cyc(70);
    chk("R10", "reset seen", seen_rst, 1'b1);
    chk("R10", "keep_ram", keep_ram, 1'b0);
    chk("R10", "cpu after", cpu_en, 1'b1);

    pdown_req = 1; cyc(1); pdown_req = 0; cyc(1);
    bod_low = 1; cyc(3);
    chk("R10", "osc from pdown", osc_en, 1'b1);
    bod_low = 0; cyc(90);
    chk("R10", "cpu after pdown bod", cpu_en, 1'b1);

    cyc(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule